// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a segment-relative offset into a linear address using an already cached 64-bit segment descriptor. It pulls the base and the limit out of the descriptor. It scales the limit by the granularity bit. It then checks that every byte of the access lies inside the segment, and it checks the access kind against the segment type. If the reference is allowed, the block returns the base plus the offset. If it is not, the block returns a fault with a cause code.

Each request lasts one cycle, marked by `req_valid`. The result, a fault cause and a copy of the descriptor appear on registered outputs one clock later, together with `rsp_valid`. The returned descriptor has its accessed bit set when the reference succeeds. The surrounding logic writes that copy back to its descriptor cache or table.

Segments can be normal or expand-down. In an expand-down data segment the valid offsets lie above the limit. The upper bound of that range is 16 or 32 bits wide, chosen by the default-size bit.

Top module: `seg_xlate_unit`

## Requirements
- R1: The 32-bit base is built from descriptor bits 39:16 (base bits 23:0) and bits 63:56 (base bits 31:24). A successful reference returns base + offset modulo 2^32.
- R2: The 20-bit raw limit is built from descriptor bits 15:0 (limit bits 15:0) and bits 51:48 (limit bits 19:16). When bit 55 is 0, the effective limit is the raw limit in bytes.
- R3: When bit 55 is 1, the effective limit is (raw limit << 12) | 0xFFF.
- R4: An access covers N = 1 << size code bytes (size code 0/1/2/3 gives 1/2/4/8 bytes). In a segment that is not expand-down, offset + N - 1 must not exceed the effective limit. A carry out of 32 bits is a limit fault.
- R5: A data segment with type bit 42 set is expand-down. Its offset must be strictly greater than the effective limit, and offset + N - 1 must not exceed the upper bound.
- R6: The expand-down upper bound is 0xFFFF when bit 54 is 0 and 0xFFFFFFFF when bit 54 is 1.
- R7: A descriptor with bit 47 (present) at 0 faults with cause 1.
- R8: A present descriptor with bit 44 at 0 (system descriptor) faults with cause 2.
- R9: Access kinds are 0 read, 1 write, 2 fetch and 3 reserved. Bit 43 set marks code and bit 41 is the read/write permission. The rules are:
  - Code allows fetch always and read only when bit 41 is 1.
  - Data allows read always and write only when bit 41 is 1.
  - Every other combination, including kind 3, faults with cause 3.
- R10: Fault causes are ranked 1 > 2 > 3 > 4, where 4 is the limit fault. Only the first that applies is reported, and 0 means no fault. On a fault the linear address output is 0.
- R11: On success the returned descriptor equals the input with bit 40 (accessed) set. On a fault it equals the input unchanged. The block never clears bit 40.
- R12: The results and `rsp_valid` appear one clock after a cycle with `req_valid` high. In a cycle with `req_valid` low, `rsp_valid` falls and the other outputs hold their values.
- R13: During reset and after it, before any request, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| desc_in | input | 64 | Cached segment descriptor |
| offset | input | 32 | Effective offset |
| size_code | input | 2 | Access size, N = 1 << size_code bytes |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| lin_addr | output | 32 | Linear address, 0 on fault |
| rsp_valid | output | 1 | Result registers hold a new response |
| fault | output | 1 | Reference refused |
| fault_cause | output | 3 | 0 none, 1 not present, 2 system, 3 access kind, 4 limit |
| desc_out | output | 64 | Descriptor with accessed bit updated |

## Verification
Several refusal reasons can apply to the same reference: not present, system, wrong kind and out of limit. The bench builds descriptors that trip two of these at once, and for each one it expects only the cause ranked highest.

A successful range check and the accessed-bit update also fall in the same response. Every vector therefore compares the returned descriptor against the input with bit 40 set, or left alone, as the expected outcome dictates. This includes a descriptor whose accessed bit is already set, to show the bit is never cleared.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE        = 3'd0,
    CAUSE_NOT_PRESENT = 3'd1,
    CAUSE_SYSTEM      = 3'd2,
    CAUSE_ACCESS      = 3'd3,
    CAUSE_LIMIT       = 3'd4
  } fault_cause_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  localparam int DESC_W   = 64;
  localparam int ADDR_W   = 32;
  localparam int LIMIT_W  = 20;
  localparam int ACC_BIT  = 40;

  typedef struct packed {
    logic [ADDR_W-1:0]  base;
    logic [LIMIT_W-1:0] limit;
    logic               gran;
    logic               big;
    logic               present;
    logic [1:0]         priv;
    logic               mem_seg;
    logic               exec;
    logic               dir;
    logic               perm;
    logic               accessed;
  } seg_fields_t;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_xlate_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output seg_fields_t       fields
);

  logic unused_bits;
  assign unused_bits = ^desc[53:52];

  always_comb begin
    fields.base     = {desc[63:56], desc[39:16]};
    fields.limit    = {desc[51:48], desc[15:0]};
    fields.gran     = desc[55];
    fields.big      = desc[54];
    fields.present  = desc[47];
    fields.priv     = desc[46:45];
    fields.mem_seg  = desc[44];
    fields.exec     = desc[43];
    fields.dir      = desc[42];
    fields.perm     = desc[41];
    fields.accessed = desc[40];
  end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_xlate_pkg::*;
#(
  parameter int          GRAN_SHIFT = 12,
  parameter logic [31:0] SMALL_TOP  = 32'h0000_FFFF
) (
  input  logic [LIMIT_W-1:0] limit,
  input  logic               gran,
  input  logic               big,
  input  logic               expand_down,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [1:0]         size_code,
  output logic               in_range
);

  localparam logic [ADDR_W-1:0] GRAN_FILL = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);
  localparam logic [ADDR_W:0]   BIG_TOP   = {1'b0, {ADDR_W{1'b1}}};

  logic [ADDR_W-1:0] eff_limit;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   last_byte;
  logic [ADDR_W:0]   upper;

  always_comb begin
    if (gran) eff_limit = (ADDR_W'(limit) << GRAN_SHIFT) | GRAN_FILL;
    else      eff_limit = ADDR_W'(limit);
    span      = ((ADDR_W+1)'(1) << size_code) - (ADDR_W+1)'(1);
    last_byte = {1'b0, offset} + span;
    upper     = big ? BIG_TOP : {1'b0, SMALL_TOP};
    if (expand_down)
      in_range = (offset > eff_limit) && (last_byte <= upper);
    else
      in_range = (last_byte <= {1'b0, eff_limit});
  end

  // R4
  always_comb begin
    lim_normal_chk: assert (!(in_range && !expand_down) || (offset <= eff_limit));
  end

  // R5
  always_comb begin
    lim_expand_chk: assert (!(in_range && expand_down) || (offset > eff_limit));
  end

endmodule

// File: rtl/seg_type_check.sv
module seg_type_check
  import seg_xlate_pkg::*;
(
  input  logic      exec,
  input  logic      perm,
  input  acc_kind_e kind,
  output logic      kind_ok
);

  always_comb begin
    unique case (kind)
      KIND_READ:  kind_ok = exec ? perm : 1'b1;
      KIND_WRITE: kind_ok = !exec && perm;
      KIND_FETCH: kind_ok = exec;
      default:    kind_ok = 1'b0;
    endcase
  end

  // R9
  always_comb begin
    kind_wr_code_chk: assert (!(kind_ok && kind == KIND_WRITE) || !exec);
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int          GRAN_SHIFT = 12,
  parameter logic [31:0] SMALL_TOP  = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] desc_in,
  input  logic [31:0] offset,
  input  logic [1:0]  size_code,
  input  logic [1:0]  acc_kind,
  output logic [31:0] lin_addr,
  output logic        rsp_valid,
  output logic        fault,
  output logic [2:0]  fault_cause,
  output logic [63:0] desc_out
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  seg_fields_t fld;
  logic        expand_down;
  logic        range_ok;
  logic        kind_ok;

  seg_desc_decode u_decode (
    .desc   (desc_in),
    .fields (fld)
  );

  assign expand_down = !fld.exec && fld.dir;

  seg_limit_check #(
    .GRAN_SHIFT (GRAN_SHIFT),
    .SMALL_TOP  (SMALL_TOP)
  ) u_limit (
    .limit       (fld.limit),
    .gran        (fld.gran),
    .big         (fld.big),
    .expand_down (expand_down),
    .offset      (offset),
    .size_code   (size_code),
    .in_range    (range_ok)
  );

  seg_type_check u_type (
    .exec    (fld.exec),
    .perm    (fld.perm),
    .kind    (acc_kind_e'(acc_kind)),
    .kind_ok (kind_ok)
  );

  // next-state
  fault_cause_e       cause_nxt;
  logic [ADDR_W-1:0]  lin_nxt;
  logic [DESC_W-1:0]  desc_nxt;
  logic               ok_nxt;
  logic               unused_priv;

  assign unused_priv = ^fld.priv ^ fld.accessed;

  always_comb begin
    if (!fld.present)      cause_nxt = CAUSE_NOT_PRESENT;
    else if (!fld.mem_seg) cause_nxt = CAUSE_SYSTEM;
    else if (!kind_ok)     cause_nxt = CAUSE_ACCESS;
    else if (!range_ok)    cause_nxt = CAUSE_LIMIT;
    else                   cause_nxt = CAUSE_NONE;
    ok_nxt   = (cause_nxt == CAUSE_NONE);
    lin_nxt  = ok_nxt ? (fld.base + offset) : '0;
    desc_nxt = desc_in;
    if (ok_nxt) desc_nxt[ACC_BIT] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lin_addr    <= '0;
      rsp_valid   <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= '0;
      desc_out    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        lin_addr    <= lin_nxt;
        fault       <= !ok_nxt;
        fault_cause <= cause_nxt;
        desc_out    <= desc_nxt;
      end
    end
  end

  // R12
  rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);

  // R7
  np_fault_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !desc_in[47]) |=> (fault && fault_cause == 3'd1));

  // R11
  acc_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && !fault) |-> desc_out[ACC_BIT]);

  // R11
  desc_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> (desc_out[63:41] == $past(desc_in[63:41]) &&
                   desc_out[39:0]  == $past(desc_in[39:0])));

  // R10
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fault |-> (lin_addr == '0 && fault_cause != 3'd0));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!req_valid && !$past(!rst_int_n)) |=> $stable(lin_addr) && $stable(fault_cause));

endmodule

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] desc_in;
  logic [31:0] offset;
  logic [1:0]  size_code;
  logic [1:0]  acc_kind;
  logic [31:0] lin_addr;
  logic        rsp_valid;
  logic        fault;
  logic [2:0]  fault_cause;
  logic [63:0] desc_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .desc_in(desc_in),
    .offset(offset), .size_code(size_code), .acc_kind(acc_kind),
    .lin_addr(lin_addr), .rsp_valid(rsp_valid), .fault(fault),
    .fault_cause(fault_cause), .desc_out(desc_out)
  );

  function automatic logic [63:0] mkd(input logic [31:0] b, input logic [19:0] l,
                                      input logic g, input logic d, input logic p,
                                      input logic s, input logic [2:0] t, input logic a);
    return {b[31:24], g, d, 2'b00, l[19:16], p, 2'b00, s, t, a, b[23:0], l[15:0]};
  endfunction

  function automatic logic [135:0] mkv(input logic [63:0] dsc, input logic [31:0] off,
                                       input logic [1:0] w, input logic [1:0] k,
                                       input logic f, input logic [2:0] c,
                                       input logic [31:0] lin);
    return {dsc, off, w, k, f, c, lin};
  endfunction

  localparam int NV = 27;
  localparam logic [135:0] VEC [0:NV-1] = '{
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'h10,  2, 0, 0, 0, 32'h0010_0010),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'hFFC, 2, 0, 0, 0, 32'h0010_0FFC),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'hFFD, 2, 0, 1, 4, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00001, 1, 1, 1, 1, 3'b001, 0), 32'h1FFF, 0, 1, 0, 0, 32'h0010_1FFF),
    mkv(mkd(32'h0010_0000, 20'h00001, 1, 1, 1, 1, 3'b001, 0), 32'h2000, 0, 0, 1, 4, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 0, 1, 3'b001, 0), 32'h10,  2, 0, 1, 1, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 0, 3'b001, 0), 32'h10,  2, 0, 1, 2, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b000, 0), 32'h10,  2, 1, 1, 3, 32'h0),
    mkv(mkd(32'h4000_0000, 20'hFFFFF, 1, 1, 1, 1, 3'b101, 0), 32'h1234_5678, 2, 2, 0, 0, 32'h5234_5678),
    mkv(mkd(32'h4000_0000, 20'hFFFFF, 1, 1, 1, 1, 3'b101, 0), 32'h10,  2, 1, 1, 3, 32'h0),
    mkv(mkd(32'h4000_0000, 20'hFFFFF, 1, 1, 1, 1, 3'b100, 0), 32'h10,  2, 0, 1, 3, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'h10,  2, 2, 1, 3, 32'h0),
    mkv(mkd(32'h0020_0000, 20'h00FFF, 0, 0, 1, 1, 3'b011, 0), 32'h1000, 1, 1, 0, 0, 32'h0020_1000),
    mkv(mkd(32'h0020_0000, 20'h00FFF, 0, 0, 1, 1, 3'b011, 0), 32'hFFF,  0, 0, 1, 4, 32'h0),
    mkv(mkd(32'h0020_0000, 20'h00FFF, 0, 0, 1, 1, 3'b011, 0), 32'hFFFE, 1, 0, 0, 0, 32'h0020_FFFE),
    mkv(mkd(32'h0020_0000, 20'h00FFF, 0, 0, 1, 1, 3'b011, 0), 32'hFFFF, 1, 0, 1, 4, 32'h0),
    mkv(mkd(32'h0020_0000, 20'h00FFF, 0, 1, 1, 1, 3'b011, 0), 32'h1_0000, 2, 0, 0, 0, 32'h0021_0000),
    mkv(mkd(32'hFFFF_F000, 20'hFFFFF, 1, 1, 1, 1, 3'b001, 0), 32'h2000, 2, 0, 0, 0, 32'h0000_1000),
    mkv(mkd(32'hFFFF_F000, 20'hFFFFF, 1, 1, 1, 1, 3'b001, 0), 32'hFFFF_FFFE, 2, 0, 1, 4, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 0, 0, 3'b001, 0), 32'h10,  2, 0, 1, 1, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 0, 3'b001, 0), 32'hFFD, 2, 0, 1, 2, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b000, 0), 32'hFFD, 2, 1, 1, 3, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 1), 32'h0,   0, 0, 0, 0, 32'h0010_0000),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'h10,  2, 3, 1, 3, 32'h0),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'hFF8, 3, 0, 0, 0, 32'h0010_0FF8),
    mkv(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'hFF9, 3, 0, 1, 4, 32'h0),
    mkv(mkd(32'h0020_0000, 20'h00FFF, 0, 1, 1, 1, 3'b011, 0), 32'hFFFF_FFFC, 2, 0, 0, 0, 32'h001F_FFFC)
  };

  function automatic string tag(input int i);
    case (i)
      0, 8:           return "R1";
      1, 2, 24, 25:   return "R4";
      3, 4:           return "R3";
      5:              return "R7";
      6:              return "R8";
      7, 9, 10, 11, 23: return "R9";
      12, 13:         return "R5";
      14, 15, 16, 26: return "R6";
      17, 18:         return "R2";
      19, 20, 21:     return "R10";
      default:        return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d, input logic [31:0] o,
                       input logic [1:0] w, input logic [1:0] k);
    req_valid = 1'b1; desc_in = d; offset = o; size_code = w; acc_kind = k;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; desc_in = '0; offset = '0;
    size_code = '0; acc_kind = '0;
    repeat (3) @(negedge clk);
    chk("R13 reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 idle lin", 64'(lin_addr), 64'd0);
    chk("R13 idle fault", 64'({fault, fault_cause}), 64'd0);
    chk("R13 idle desc", desc_out, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      logic [63:0]  d, dexp;
      v = VEC[i];
      d = v[135:72];
      drive(d, v[71:40], v[39:38], v[37:36]);
      dexp = v[35] ? d : (d | (64'd1 << 40));
      chk({tag(i), " R12 valid"}, 64'(rsp_valid), 64'd1);
      chk({tag(i), " R10 fault"}, 64'(fault), 64'(v[35]));
      chk({tag(i), " R10 cause"}, 64'(fault_cause), 64'(v[34:32]));
      chk({tag(i), " R1 lin"}, 64'(lin_addr), 64'(v[31:0]));
      chk({tag(i), " R11 desc"}, desc_out, dexp);
    end

    // R12: idle cycle with new inputs leaves results alone
    drive(mkd(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'h20, 0, 0);
    desc_in = mkd(32'h0, 20'h0, 0, 0, 0, 0, 3'b0, 0);
    offset = 32'h5;
    @(posedge clk); @(negedge clk);
    chk("R12 idle valid", 64'(rsp_valid), 64'd0);
    chk("R12 idle hold lin", 64'(lin_addr), 64'h0010_0020);
    chk("R12 idle hold cause", 64'(fault_cause), 64'd0);

    // R13: reset in the middle clears outputs at once
    drive(mkd(32'h0030_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'h4, 0, 0);
    rst_n = 1'b0;
    #1;
    chk("R13 mid reset lin", 64'(lin_addr), 64'd0);
    chk("R13 mid reset desc", desc_out, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(mkd(32'h0030_0000, 20'h00FFF, 0, 1, 1, 1, 3'b001, 0), 32'h4, 0, 0);
    chk("R1 after reset lin", 64'(lin_addr), 64'h0030_0004);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule